// File: doc/BRIEF.md
# Dual-Port Peripheral Interface Adapter

This block is a memory-mapped parallel I/O peripheral with two 8-bit sides, A and B. A processor reaches it through a synchronous bus with a chip select, separate read and write strobes, a two-bit offset and byte-wide data. Each side has three registers: a direction register, an output register and a control register. The control register decides three things. It chooses whether the side's data offset reaches the direction register or the port. It sets the behaviour of the side's two control lines. It gates the side's active-low interrupt output.

The first control line of each side is an input only. Its programmed edge raises the top status flag, and software can poll that flag through the sign bit of a control read. The second control line can be an input that raises the second flag. It can also be an output that makes a handshake with the port: side A signals after its port data is read, and side B signals after its port data is written. Both flags are read-only. A read of the port data clears them.

Top module: `pio_adapter`

## Requirements
- R1: After reset every register reads 0x00 at all four offsets. Both interrupt outputs are high. No pin or control line is driven as an output (all output enables are 0).
- R2: Offset 0 selects side A data, offset 1 selects A control, offset 2 selects B data and offset 3 selects B control. Each holds its own value.
- R3: With control bit 2 at 0, the side's data offset reads and writes the direction register. With bit 2 at 1, it reaches the output register.
- R4: A direction bit of 1 drives that pin from the output register (output enable 1). A port read returns the output-register bit where the direction bit is 1 and the pin level where it is 0.
- R5: A control write stores bits 5:0 only. Bits 7 and 6 are status and ignore writes, so writing 0xA7 reads back 0x27.
- R6: Control bit 1 picks the active edge of the first control line: 1 for rising, 0 for falling. An active edge sets control bit 7, which reads 1 from the third rising clock edge after the pin changes. An inactive edge has no effect.
- R7: The interrupt output is low while bit 7 is 1 and bit 0 is 1, and it is high again once the flag clears.
- R8: A read of the data offset with bit 2 at 1 clears both bits 7 and 6 of that side. Control reads and direction-register reads leave the flags set.
- R9: If an active edge arrives in the same cycle as a clearing read, the flag stays set.
- R10: With bit 5 at 0 the second control line is an input. Bit 4 picks its active edge (1 is rising). That edge sets bit 6, and bit 6 drives the interrupt low only when bit 3 is 1.
- R11: Bits 5:3 = 100 make the second line a handshake output. It goes low after a port-data read on side A, or after a port-data write on side B. It goes high again on the next active edge of the first line, in the same cycle as that edge sets the flag.
- R12: Bits 5:3 = 101 make the second line go low for exactly one cycle after the same access that R11 uses.
- R13: Bits 5:3 = 11x drive the second line to the level of bit 3. Its output enable equals bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe, side effects on the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while chip select and read are high |
| a_pin_in | input | 8 | Side A pin levels |
| a_pin_out | output | 8 | Side A output register |
| a_pin_oe | output | 8 | Side A pin output enables |
| a_sense_in | input | 1 | Side A first control line |
| a_hs_in | input | 1 | Side A second control line, input level |
| a_hs_out | output | 1 | Side A second control line, output level |
| a_hs_oe | output | 1 | Side A second control line, output enable |
| a_irq_n | output | 1 | Side A interrupt, active low |
| b_pin_in | input | 8 | Side B pin levels |
| b_pin_out | output | 8 | Side B output register |
| b_pin_oe | output | 8 | Side B pin output enables |
| b_sense_in | input | 1 | Side B first control line |
| b_hs_in | input | 1 | Side B second control line, input level |
| b_hs_out | output | 1 | Side B second control line, output level |
| b_hs_oe | output | 1 | Side B second control line, output enable |
| b_irq_n | output | 1 | Side B interrupt, active low |

## Verification
Read data is combinational, so the bench samples it while the strobe is still high, before the edge that applies the read's side effects. Register writes and handshake drops take effect on the strobe's clock edge and are sampled at the next falling edge. A control-line change reaches the flag, the interrupt and the handshake release on the third rising edge after it. The bench changes pins on a falling edge and counts three falling edges before it samples. It also samples one edge earlier to confirm that nothing has changed yet. The same-cycle case is timed so that the clearing read's strobe covers exactly that third edge.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the dual-port adapter.
// Assumes an 8-bit control register with fixed bit meanings.
package pio_pkg;
    localparam int CTL_FLAG1    = 7;
    localparam int CTL_FLAG2    = 6;
    localparam int CTL_AUX_DIR  = 5;
    localparam int CTL_AUX_B    = 4;
    localparam int CTL_AUX_A    = 3;
    localparam int CTL_PORT_SEL = 2;
    localparam int CTL_EDGE_POL = 1;
    localparam int CTL_IRQ_EN   = 0;
    localparam int CFG_W        = 6;

    // Output modes of the second control line (bits 4:3 while bit 5 is set)
    typedef enum logic [1:0] {
        AUX_HANDSHAKE = 2'b00,
        AUX_PULSE     = 2'b01,
        AUX_FORCE_LO  = 2'b10,
        AUX_FORCE_HI  = 2'b11
    } aux_mode_e;
endpackage

// File: rtl/pio_edge_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer followed by a one-register edge detector.
// Assumes STAGES >= 2 and that the input is low during reset.
module pio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the pin through the synchronizer and keep the previous sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            last_q  <= chain_q[STAGES-1];
        end
    end

    // Compare synchronized level with its previous value
    always_comb begin
        rise = chain_q[STAGES-1] & ~last_q;
        fall = ~chain_q[STAGES-1] & last_q;
    end
endmodule

// File: rtl/pio_side.sv
`timescale 1ns/1ps
// One side of the adapter: direction, output and control registers,
// flag logic and the second control line.
// TRIG_ON_WRITE picks the access that drives the handshake: 0 for a port
// read, 1 for a port write. Assumes DATA_W >= 8.
module pio_side
    import pio_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SYNC_STAGES   = 2,
    parameter bit TRIG_ON_WRITE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_sel,
    input  logic              ctl_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pin_in,
    input  logic              sense_in,
    input  logic              aux_in,
    output logic [DATA_W-1:0] data_rd,
    output logic [7:0]        ctl_rd,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe,
    output logic              aux_out,
    output logic              aux_oe,
    output logic              irq_n,
    output logic              sense_hit
);
    logic [DATA_W-1:0] dir_q, out_q;
    logic [CFG_W-1:0]  cfg_q;
    logic              flag1_q, flag2_q, aux_q;
    logic              s_rise, s_fall, x_rise, x_fall;
    logic              hit1, hit2, clr, trig, port_sel;
    aux_mode_e         mode;

    pio_edge_sync #(.STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .pin(sense_in), .rise(s_rise), .fall(s_fall)
    );
    pio_edge_sync #(.STAGES(SYNC_STAGES)) u_aux (
        .clk(clk), .rst_n(rst_n), .pin(aux_in), .rise(x_rise), .fall(x_fall)
    );

    // Decode active edges, the clearing read and the handshake trigger
    always_comb begin
        port_sel = cfg_q[CTL_PORT_SEL];
        mode     = aux_mode_e'(cfg_q[CTL_AUX_B:CTL_AUX_A]);
        hit1     = cfg_q[CTL_EDGE_POL] ? s_rise : s_fall;
        hit2     = ~cfg_q[CTL_AUX_DIR] & (cfg_q[CTL_AUX_B] ? x_rise : x_fall);
        clr      = data_sel & rd_stb & port_sel;
        trig     = data_sel & port_sel & (TRIG_ON_WRITE ? wr_stb : rd_stb);
    end

    // Processor-written registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
            cfg_q <= '0;
        end else begin
            if (ctl_sel && wr_stb)
                cfg_q <= wdata[CFG_W-1:0];
            if (data_sel && wr_stb) begin
                if (port_sel)
                    out_q <= wdata;
                else
                    dir_q <= wdata;
            end
        end
    end

    // Status flags: an edge wins over a clearing read in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag1_q <= 1'b0;
            flag2_q <= 1'b0;
        end else begin
            if (hit1)
                flag1_q <= 1'b1;
            else if (clr)
                flag1_q <= 1'b0;
            if (hit2)
                flag2_q <= 1'b1;
            else if (clr)
                flag2_q <= 1'b0;
        end
    end

    // Second control line output level by mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_q <= 1'b1;
        end else if (!cfg_q[CTL_AUX_DIR]) begin
            aux_q <= 1'b1;
        end else begin
            unique case (mode)
                AUX_HANDSHAKE: begin
                    if (trig)
                        aux_q <= 1'b0;
                    else if (hit1)
                        aux_q <= 1'b1;
                end
                AUX_PULSE:    aux_q <= ~trig;
                AUX_FORCE_LO: aux_q <= 1'b0;
                AUX_FORCE_HI: aux_q <= 1'b1;
            endcase
        end
    end

    // Read values and pin-facing outputs
    always_comb begin
        data_rd   = port_sel ? ((out_q & dir_q) | (pin_in & ~dir_q)) : dir_q;
        ctl_rd    = {flag1_q, flag2_q, cfg_q};
        pin_out   = out_q;
        pin_oe    = dir_q;
        aux_out   = aux_q;
        aux_oe    = cfg_q[CTL_AUX_DIR];
        irq_n     = ~((flag1_q & cfg_q[CTL_IRQ_EN]) |
                      (flag2_q & cfg_q[CTL_AUX_A] & ~cfg_q[CTL_AUX_DIR]));
        sense_hit = hit1;
    end
endmodule

// File: rtl/pio_adapter.sv
`timescale 1ns/1ps
// Top of the dual-port adapter: decodes the four bus offsets, builds the
// two sides and multiplexes the read data.
// Assumes one strobe per access, sampled on the rising clock edge.
module pio_adapter #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] a_pin_in,
    output logic [DATA_W-1:0] a_pin_out,
    output logic [DATA_W-1:0] a_pin_oe,
    input  logic              a_sense_in,
    input  logic              a_hs_in,
    output logic              a_hs_out,
    output logic              a_hs_oe,
    output logic              a_irq_n,
    input  logic [DATA_W-1:0] b_pin_in,
    output logic [DATA_W-1:0] b_pin_out,
    output logic [DATA_W-1:0] b_pin_oe,
    input  logic              b_sense_in,
    input  logic              b_hs_in,
    output logic              b_hs_out,
    output logic              b_hs_oe,
    output logic              b_irq_n
);
    localparam int SIDES = 2;

    logic [DATA_W-1:0] pin_in_v  [SIDES];
    logic [DATA_W-1:0] pin_out_v [SIDES];
    logic [DATA_W-1:0] pin_oe_v  [SIDES];
    logic [DATA_W-1:0] data_rd_v [SIDES];
    logic [7:0]        ctl_rd_v  [SIDES];
    logic              sense_v   [SIDES];
    logic              aux_in_v  [SIDES];
    logic              aux_out_v [SIDES];
    logic              aux_oe_v  [SIDES];
    logic              irq_n_v   [SIDES];
    logic              hit_v     [SIDES];

    assign pin_in_v[0] = a_pin_in;
    assign pin_in_v[1] = b_pin_in;
    assign sense_v[0]  = a_sense_in;
    assign sense_v[1]  = b_sense_in;
    assign aux_in_v[0] = a_hs_in;
    assign aux_in_v[1] = b_hs_in;

    // Side 0 hands off on a port read, side 1 on a port write
    for (genvar gi = 0; gi < SIDES; gi++) begin : g_side
        localparam logic [1:0] LOC_DATA = 2'(2 * gi);
        localparam logic [1:0] LOC_CTL  = 2'(2 * gi + 1);
        pio_side #(
            .DATA_W(DATA_W),
            .SYNC_STAGES(SYNC_STAGES),
            .TRIG_ON_WRITE(gi == 1)
        ) u_side (
            .clk(clk),
            .rst_n(rst_n),
            .data_sel(bus_cs && bus_addr == LOC_DATA),
            .ctl_sel(bus_cs && bus_addr == LOC_CTL),
            .rd_stb(bus_rd),
            .wr_stb(bus_wr),
            .wdata(bus_wdata),
            .pin_in(pin_in_v[gi]),
            .sense_in(sense_v[gi]),
            .aux_in(aux_in_v[gi]),
            .data_rd(data_rd_v[gi]),
            .ctl_rd(ctl_rd_v[gi]),
            .pin_out(pin_out_v[gi]),
            .pin_oe(pin_oe_v[gi]),
            .aux_out(aux_out_v[gi]),
            .aux_oe(aux_oe_v[gi]),
            .irq_n(irq_n_v[gi]),
            .sense_hit(hit_v[gi])
        );
    end

    assign a_pin_out = pin_out_v[0];
    assign a_pin_oe  = pin_oe_v[0];
    assign a_hs_out  = aux_out_v[0];
    assign a_hs_oe   = aux_oe_v[0];
    assign a_irq_n   = irq_n_v[0];
    assign b_pin_out = pin_out_v[1];
    assign b_pin_oe  = pin_oe_v[1];
    assign b_hs_out  = aux_out_v[1];
    assign b_hs_oe   = aux_oe_v[1];
    assign b_irq_n   = irq_n_v[1];

    // Read multiplexer, zero when not reading
    always_comb begin
        bus_rdata = '0;
        if (bus_cs && bus_rd) begin
            unique case (bus_addr)
                2'd0: bus_rdata = data_rd_v[0];
                2'd1: bus_rdata = DATA_W'(ctl_rd_v[0]);
                2'd2: bus_rdata = data_rd_v[1];
                2'd3: bus_rdata = DATA_W'(ctl_rd_v[1]);
            endcase
        end
    end
endmodule

// File: rtl/pio_adapter_chk.sv
`timescale 1ns/1ps
// Assertion checker for pio_adapter, attached through bind.
// Assumes control bit meanings from pio_pkg.
module pio_adapter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_cs,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [5:0] cfg_wdata,
    input logic [7:0] a_ctl,
    input logic [7:0] b_ctl,
    input logic       a_hit,
    input logic       b_hit,
    input logic       a_hs_out,
    input logic       b_hs_out,
    input logic       a_irq_n,
    input logic       b_irq_n
);
    assert_flag_rise_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_ctl[7]) |-> $past(a_hit));
    assert_flag_rise_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_ctl[7]) |-> $past(b_hit));
    assert_flag_clear_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_ctl[7]) |-> $past(bus_cs && bus_rd && bus_addr == 2'd0 && a_ctl[2]));
    assert_flag_clear_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_ctl[7]) |-> $past(bus_cs && bus_rd && bus_addr == 2'd2 && b_ctl[2]));
    assert_edge_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        a_hit |=> a_ctl[7]);
    assert_irq_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !a_irq_n |-> (a_ctl[7] || a_ctl[6]));
    assert_irq_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !b_irq_n |-> (b_ctl[7] || b_ctl[6]));
    assert_ctl_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_wr && !bus_rd && bus_addr == 2'd1 && !a_hit)
        |=> (a_ctl[7] == $past(a_ctl[7]) && a_ctl[5:0] == $past(cfg_wdata)));
    assert_hand_a_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_rd && !bus_wr && bus_addr == 2'd0 && a_ctl[2] && a_ctl[5:3] == 3'b100)
        |=> !a_hs_out);
    assert_hand_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_wr && bus_addr == 2'd2 && b_ctl[2] && b_ctl[5:3] == 3'b100)
        |=> !b_hs_out);
endmodule

bind pio_adapter pio_adapter_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .bus_cs(bus_cs),
    .bus_rd(bus_rd),
    .bus_wr(bus_wr),
    .bus_addr(bus_addr),
    .cfg_wdata(bus_wdata[5:0]),
    .a_ctl(ctl_rd_v[0]),
    .b_ctl(ctl_rd_v[1]),
    .a_hit(hit_v[0]),
    .b_hit(hit_v[1]),
    .a_hs_out(a_hs_out),
    .b_hs_out(b_hs_out),
    .a_irq_n(a_irq_n),
    .b_irq_n(b_irq_n)
);

// File: tb/sim_pio_adapter.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table for register access, then directed
// tests for edges, flags, interrupts and the second control line.
module sim_pio_adapter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] a_pin_in = 8'h3C, b_pin_in = 8'h80;
    logic [7:0] a_pin_out, a_pin_oe, b_pin_out, b_pin_oe;
    logic       a_sense_in = 1'b0, a_hs_in = 1'b0, b_sense_in = 1'b0, b_hs_in = 1'b0;
    logic       a_hs_out, a_hs_oe, a_irq_n, b_hs_out, b_hs_oe, b_irq_n;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    pio_adapter u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .a_pin_in(a_pin_in), .a_pin_out(a_pin_out), .a_pin_oe(a_pin_oe),
        .a_sense_in(a_sense_in), .a_hs_in(a_hs_in), .a_hs_out(a_hs_out),
        .a_hs_oe(a_hs_oe), .a_irq_n(a_irq_n),
        .b_pin_in(b_pin_in), .b_pin_out(b_pin_out), .b_pin_oe(b_pin_oe),
        .b_sense_in(b_sense_in), .b_hs_in(b_hs_in), .b_hs_out(b_hs_out),
        .b_hs_oe(b_hs_oe), .b_irq_n(b_irq_n)
    );

    // Vector: {req[3:0], is_read, addr[1:0], data[7:0], expect[7:0]}
    localparam int NVEC = 16;
    localparam logic [22:0] VEC [NVEC] = '{
        {4'd3, 1'b0, 2'd0, 8'hFF, 8'h00},   // R3 A direction
        {4'd3, 1'b1, 2'd0, 8'h00, 8'hFF},
        {4'd3, 1'b0, 2'd2, 8'h7F, 8'h00},   // R3 B direction
        {4'd3, 1'b1, 2'd2, 8'h00, 8'h7F},
        {4'd5, 1'b0, 2'd1, 8'hA7, 8'h00},   // R5 flags ignore writes
        {4'd5, 1'b1, 2'd1, 8'h00, 8'h27},
        {4'd5, 1'b0, 2'd3, 8'hA7, 8'h00},
        {4'd5, 1'b1, 2'd3, 8'h00, 8'h27},
        {4'd4, 1'b0, 2'd0, 8'h5A, 8'h00},   // R4 all outputs
        {4'd4, 1'b1, 2'd0, 8'h00, 8'h5A},
        {4'd4, 1'b0, 2'd2, 8'h43, 8'h00},   // R4 pin 7 input
        {4'd4, 1'b1, 2'd2, 8'h00, 8'hC3},
        {4'd3, 1'b0, 2'd1, 8'h23, 8'h00},   // R3 back to direction
        {4'd3, 1'b1, 2'd0, 8'h00, 8'hFF},
        {4'd2, 1'b0, 2'd1, 8'h27, 8'h00},   // R2 offsets distinct
        {4'd2, 1'b1, 2'd1, 8'h00, 8'h27}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_cs = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            bus_read(2'(i), rv);
            check($sformatf("R1 offset %0d", i), rv, 8'h00);
        end
        check("R1 irq", {6'd0, a_irq_n, b_irq_n}, 8'h03);
        check("R1 oe", a_pin_oe | b_pin_oe, 8'h00);
        check("R1 hs oe", {6'd0, a_hs_oe, b_hs_oe}, 8'h00);

        // Vector table: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][18]) begin
                bus_read(VEC[i][17:16], rv);
                check($sformatf("R%0d vector %0d", VEC[i][22:19], i), rv, VEC[i][7:0]);
            end else begin
                bus_write(VEC[i][17:16], VEC[i][15:8]);
            end
        end
        check("R4 a pins", a_pin_out, 8'h5A);
        check("R4 a oe", a_pin_oe, 8'hFF);
        check("R4 b oe", b_pin_oe, 8'h7F);
        check("R11 a low after read", {7'd0, a_hs_out}, 8'h00);
        check("R11 b low after write", {7'd0, b_hs_out}, 8'h00);
        check("R13 a hs oe", {7'd0, a_hs_oe}, 8'h01);

        // R6 R7 R11 rising edge on side A
        @(negedge clk); a_sense_in = 1'b1;
        wait_neg(2);
        check("R6 not yet at edge 2", {7'd0, a_irq_n}, 8'h01);
        wait_neg(1);
        check("R7 irq low", {7'd0, a_irq_n}, 8'h00);
        check("R11 a released", {7'd0, a_hs_out}, 8'h01);
        bus_read(2'd1, rv); check("R6 flag set", rv, 8'hA7);
        bus_read(2'd1, rv); check("R8 ctl read keeps flag", rv, 8'hA7);
        bus_read(2'd0, rv); check("R8 port read value", rv, 8'h5A);
        bus_read(2'd1, rv); check("R8 flag cleared", rv, 8'h27);
        check("R7 irq high", {7'd0, a_irq_n}, 8'h01);
        check("R11 a low again", {7'd0, a_hs_out}, 8'h00);

        // R6 falling polarity and inactive edge
        bus_write(2'd1, 8'h25);
        @(negedge clk); a_sense_in = 1'b0;
        wait_neg(3);
        bus_read(2'd1, rv); check("R6 falling sets", rv, 8'hA5);
        bus_read(2'd0, rv);
        @(negedge clk); a_sense_in = 1'b1;
        wait_neg(4);
        bus_read(2'd1, rv); check("R6 inactive edge ignored", rv, 8'h25);

        // R9 edge in the same cycle as the clearing read
        bus_write(2'd1, 8'h27);
        @(negedge clk); a_sense_in = 1'b0;
        wait_neg(4);
        @(negedge clk); a_sense_in = 1'b1;
        wait_neg(3);
        @(negedge clk); a_sense_in = 1'b0;
        wait_neg(4);
        @(negedge clk); a_sense_in = 1'b1;
        @(negedge clk);
        bus_read(2'd0, rv);
        bus_read(2'd1, rv); check("R9 flag survives", rv, 8'hA7);
        bus_read(2'd0, rv);
        bus_read(2'd1, rv); check("R9 later clear", rv, 8'h27);

        // R10 second line as input on side B
        bus_write(2'd3, 8'h1F);
        check("R10 b hs oe", {7'd0, b_hs_oe}, 8'h00);
        @(negedge clk); b_hs_in = 1'b1;
        wait_neg(3);
        check("R10 irq from line 2", {7'd0, b_irq_n}, 8'h00);
        bus_read(2'd3, rv); check("R10 flag2 set", rv, 8'h5F);
        bus_read(2'd2, rv); check("R10 port read", rv, 8'hC3);
        bus_read(2'd3, rv); check("R10 flag2 cleared", rv, 8'h1F);
        bus_write(2'd3, 8'h07);
        @(negedge clk); b_hs_in = 1'b0;
        wait_neg(3);
        check("R10 masked irq", {7'd0, b_irq_n}, 8'h01);
        bus_read(2'd3, rv); check("R10 falling sets flag2", rv, 8'h47);
        bus_read(2'd2, rv);

        // R11 handshake on side B
        bus_write(2'd3, 8'h27);
        check("R11 b idle high", {7'd0, b_hs_out}, 8'h01);
        bus_write(2'd2, 8'h11);
        check("R11 b low after write", {7'd0, b_hs_out}, 8'h00);
        @(negedge clk); b_sense_in = 1'b1;
        wait_neg(3);
        check("R11 b released", {7'd0, b_hs_out}, 8'h01);
        check("R7 b irq", {7'd0, b_irq_n}, 8'h00);
        bus_read(2'd2, rv);

        // R12 pulse mode on side A
        bus_write(2'd1, 8'h2F);
        bus_read(2'd0, rv);
        check("R12 pulse low", {7'd0, a_hs_out}, 8'h00);
        @(negedge clk);
        check("R12 pulse ends", {7'd0, a_hs_out}, 8'h01);

        // R13 forced levels
        bus_write(2'd1, 8'h37);
        @(negedge clk);
        check("R13 forced low", {7'd0, a_hs_out}, 8'h00);
        bus_write(2'd1, 8'h3F);
        @(negedge clk);
        check("R13 forced high", {7'd0, a_hs_out}, 8'h01);
        bus_write(2'd1, 8'h07);
        check("R13 input mode oe", {7'd0, a_hs_oe}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule